// File: doc/BRIEF.md
# I2C Transaction Sequencer

This block sits above a bit-level I2C engine and turns a list of message descriptors into one complete bus transaction. It issues a START, sends each message's address phase and data bytes, places a repeated START between messages, and always finishes with a STOP. Once the STOP has completed it reports how many messages finished, or which kind of fault cut the transaction short.

Descriptors arrive one at a time over a valid/ready handshake. Each descriptor carries:

- a 7-bit or 10-bit target address,
- a read or write direction,
- a byte count,
- an option to treat NACKs as success,
- an option to clock no acknowledge bit on reads,
- an option to skip the repeated START and the address phase,
- a marker that flags the last message of the transaction.

Write bytes are pulled from a byte stream. Read bytes are pushed out as one-cycle pulses.

The engine below the sequencer takes one command at a time: START, RESTART, STOP, a long DELAY, a byte WRITE, or a byte READ with ACK, NACK or no acknowledge. The sequencer holds the command until the engine pulses done. With the done pulse the engine returns the acknowledge seen on a write, the byte received on a read, and a clock-stretch timeout flag.

Top module: `i2c_xact_seq`

## Requirements
- R1: A 7-bit message sends one address byte equal to the address shifted left by one, with bit 0 set to 1 for a read and 0 for a write.
- R2: A 10-bit message sends a first byte of 8'hF0 OR (address bits 9:8 placed in bits 2:1), with bit 0 cleared. It then sends a second byte equal to address bits 7:0.
- R3: For a 10-bit read, the two address bytes are followed by RESTART and then by the first byte again with bit 0 set. After that the data phase starts.
- R4: When an address byte (the 7-bit byte, or the first 10-bit byte) is NACKed, the block retries up to `cfg_retries` times. Each retry issues STOP, then DELAY, then START, then resends the same byte. When ignore-NACK is set, the number of retries is zero.
- R5: With ignore-NACK set, a NACK on an address byte or a data byte counts as success and the transfer goes on.
- R6: A no-START message issues no RESTART and no address bytes; its data bytes follow the previous bytes directly. Every other message after the first is preceded by RESTART. The first message always follows a START.
- R7: A read of N bytes issues READ_ACK for bytes 1 to N-1 and READ_NACK for byte N. With no-ACK-on-read set, every byte is issued as READ_NONE. Each received byte appears once on `rd_data` with a one-cycle `rd_valid`, in bus order.
- R8: The transaction ends early in three cases, and the error code records which one: a final address NACK (code 1), a data-write NACK without ignore-NACK (code 2), or a timeout on any byte command (code 3). On success the code is 0 and `status_ok` is 1. `status_count` is the number of messages that completed in full.
- R9: Every transaction ends with exactly one final STOP, and no command follows it. The STOP completes before `status_done` pulses. A command stays valid and stable until the engine pulses `eng_done`.
- R10: After an early end, the descriptors that remain, up to and including the one flagged last, are accepted and dropped. No descriptor is accepted while an engine command is pending.
- R11: Command codes on `eng_cmd_op`: 0 START, 1 RESTART, 2 STOP, 3 DELAY, 4 WRITE, 5 READ_ACK, 6 READ_NACK, 7 READ_NONE. `eng_cmd_data` carries the byte for WRITE and is 0 for every other command. After reset no command is valid and `status_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_retries | input | RTRY_W | Number of address retries allowed after a NACK |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor accepted this cycle when valid |
| desc_addr | input | 10 | Target address (bits 6:0 used in 7-bit mode) |
| desc_rd | input | 1 | 1 = read, 0 = write |
| desc_ten | input | 1 | 10-bit address mode |
| desc_ign_nack | input | 1 | Treat NACKs as success |
| desc_no_ack | input | 1 | Clock no acknowledge bit on read bytes |
| desc_no_start | input | 1 | Skip RESTART and the address phase |
| desc_len | input | LEN_W | Byte count |
| desc_last | input | 1 | Last message of the transaction |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte taken when valid |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Received byte pulse |
| rd_data | output | 8 | Received byte |
| eng_cmd_valid | output | 1 | Engine command pending |
| eng_cmd_op | output | 3 | Engine command code |
| eng_cmd_data | output | 8 | Byte for WRITE |
| eng_done | input | 1 | Engine finished the pending command |
| eng_ack | input | 1 | ACK seen on a WRITE |
| eng_tmo | input | 1 | Clock-stretch timeout on a byte command |
| eng_rdata | input | 8 | Byte received on a READ |
| status_done | output | 1 | Transaction finished (one cycle) |
| status_ok | output | 1 | No error |
| status_err | output | 2 | Error code |
| status_count | output | CNT_W | Messages completed |

## Verification
The bench runs nine transactions and compares every engine command, every received byte and the final status against a behavioural model.

- **Plain 7-bit transactions.** A write followed by a read checks the address encoding and the ACK/NACK placement on reads.
- **10-bit transactions.** A 10-bit read and a 10-bit write tell the repeated-START read path apart from the plain two-byte write path. A 10-bit read whose repeated address byte is NACKed once shows that a retry resends the byte with bit 0 set and does not go back to the write form.
- **Retries.** A NACK schedule that succeeds on the final permitted retry, and one that runs out of retries, show where the retry limit falls.
- **ignore-NACK, no-START and no-ACK.** A transaction that mixes no-START, no-ACK reads and a zero-length message isolates those options. An ignore-NACK write under NACKs shows that the retry count is forced to zero.
- **Early ends.** A data NACK and a read timeout each separate the error codes, and they show the completed-message count and the dropping of the descriptors that remain.

// File: rtl/i2c_xact_seq.sv
module i2c_xact_seq #(
  parameter int LEN_W  = 8,
  parameter int CNT_W  = 8,
  parameter int RTRY_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RTRY_W-1:0] cfg_retries,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [9:0]        desc_addr,
  input  logic              desc_rd,
  input  logic              desc_ten,
  input  logic              desc_ign_nack,
  input  logic              desc_no_ack,
  input  logic              desc_no_start,
  input  logic [LEN_W-1:0]  desc_len,
  input  logic              desc_last,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              eng_cmd_valid,
  output logic [2:0]        eng_cmd_op,
  output logic [7:0]        eng_cmd_data,
  input  logic              eng_done,
  input  logic              eng_ack,
  input  logic              eng_tmo,
  input  logic [7:0]        eng_rdata,
  output logic              status_done,
  output logic              status_ok,
  output logic [1:0]        status_err,
  output logic [CNT_W-1:0]  status_count
);
  localparam logic [2:0] OP_START = 3'd0, OP_RESTART = 3'd1, OP_STOP = 3'd2,
                         OP_DELAY = 3'd3, OP_WRITE = 3'd4, OP_RD_ACK = 3'd5,
                         OP_RD_NACK = 3'd6, OP_RD_NONE = 3'd7;
  localparam logic [1:0] E_NONE = 2'd0, E_ADDR = 2'd1, E_DATA = 2'd2, E_TMO = 2'd3;
  localparam logic [LEN_W-1:0] ONE_LEFT = LEN_W'(1);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_FETCH, S_RESTART, S_ADDR, S_ADDR2, S_AREST, S_RSTOP,
    S_RDLY, S_RSTART, S_DATA, S_WGET, S_WR, S_STOP, S_DRAIN, S_REPORT
  } st_t;

  st_t              st;
  logic [9:0]       m_addr;
  logic             m_rd, m_ten, m_ign, m_noack, m_last;
  logic [LEN_W-1:0] m_left;
  logic             rep;
  logic [RTRY_W-1:0] tries;
  logic [7:0]       wbyte;
  logic [1:0]       err;
  logic [CNT_W-1:0] cnt;

  logic [7:0]        first_byte;
  logic [RTRY_W-1:0] retry_lim;
  logic              rd_data_phase;
  logic              byte_ok;

  assign first_byte    = m_ten ? {5'b11110, m_addr[9:8], rep} : {m_addr[6:0], m_rd};
  assign retry_lim     = m_ign ? '0 : cfg_retries;
  assign rd_data_phase = (st == S_DATA) && m_rd && (m_left != '0);
  assign byte_ok       = eng_ack || m_ign;

  assign desc_ready   = (st == S_IDLE) || (st == S_FETCH) || (st == S_DRAIN);
  assign wr_ready     = (st == S_WGET);
  assign status_done  = (st == S_REPORT);
  assign status_err   = err;
  assign status_ok    = (err == E_NONE);
  assign status_count = cnt;

  always_comb begin
    eng_cmd_valid = 1'b1;
    eng_cmd_data  = 8'h00;
    eng_cmd_op    = OP_START;
    case (st)
      S_START, S_RSTART:  eng_cmd_op = OP_START;
      S_RESTART, S_AREST: eng_cmd_op = OP_RESTART;
      S_STOP, S_RSTOP:    eng_cmd_op = OP_STOP;
      S_RDLY:             eng_cmd_op = OP_DELAY;
      S_ADDR:  begin eng_cmd_op = OP_WRITE; eng_cmd_data = first_byte;  end
      S_ADDR2: begin eng_cmd_op = OP_WRITE; eng_cmd_data = m_addr[7:0]; end
      S_WR:    begin eng_cmd_op = OP_WRITE; eng_cmd_data = wbyte;       end
      S_DATA: begin
        eng_cmd_valid = rd_data_phase;
        eng_cmd_op    = m_noack ? OP_RD_NONE :
                        (m_left == ONE_LEFT) ? OP_RD_NACK : OP_RD_ACK;
      end
      default: eng_cmd_valid = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      m_addr   <= '0;
      m_rd     <= 1'b0;
      m_ten    <= 1'b0;
      m_ign    <= 1'b0;
      m_noack  <= 1'b0;
      m_last   <= 1'b0;
      m_left   <= '0;
      rep      <= 1'b0;
      tries    <= '0;
      wbyte    <= '0;
      err      <= E_NONE;
      cnt      <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (desc_valid && ((st == S_IDLE) || (st == S_FETCH))) begin
        m_addr  <= desc_addr;
        m_rd    <= desc_rd;
        m_ten   <= desc_ten;
        m_ign   <= desc_ign_nack;
        m_noack <= desc_no_ack;
        m_last  <= desc_last;
        m_left  <= desc_len;
      end
      case (st)
        S_IDLE: if (desc_valid) begin
          cnt <= '0;
          err <= E_NONE;
          st  <= S_START;
        end
        S_FETCH: if (desc_valid) st <= desc_no_start ? S_DATA : S_RESTART;
        S_START, S_RESTART: if (eng_done) begin
          tries <= '0;
          rep   <= 1'b0;
          if (st == S_START && desc_no_start_q) st <= S_DATA;
          else st <= S_ADDR;
        end
        S_AREST: if (eng_done) begin
          tries <= '0;
          rep   <= 1'b1;
          st    <= S_ADDR;
        end
        S_ADDR: if (eng_done) begin
          if (eng_tmo) begin
            err <= E_TMO;
            st  <= S_STOP;
          end else if (byte_ok) begin
            st <= (m_ten && !rep) ? S_ADDR2 : S_DATA;
          end else if (tries < retry_lim) begin
            tries <= tries + 1'b1;
            st    <= S_RSTOP;
          end else begin
            err <= E_ADDR;
            st  <= S_STOP;
          end
        end
        S_ADDR2: if (eng_done) begin
          if (eng_tmo) begin
            err <= E_TMO;
            st  <= S_STOP;
          end else if (byte_ok) begin
            st <= m_rd ? S_AREST : S_DATA;
          end else begin
            err <= E_ADDR;
            st  <= S_STOP;
          end
        end
        S_RSTOP:  if (eng_done) st <= S_RDLY;
        S_RDLY:   if (eng_done) st <= S_RSTART;
        S_RSTART: if (eng_done) st <= S_ADDR;
        S_DATA: begin
          if (m_left == '0) begin
            cnt <= cnt + 1'b1;
            st  <= m_last ? S_STOP : S_FETCH;
          end else if (!m_rd) begin
            st <= S_WGET;
          end else if (eng_done) begin
            if (eng_tmo) begin
              err <= E_TMO;
              st  <= S_STOP;
            end else begin
              rd_valid <= 1'b1;
              rd_data  <= eng_rdata;
              m_left   <= m_left - 1'b1;
            end
          end
        end
        S_WGET: if (wr_valid) begin
          wbyte <= wr_data;
          st    <= S_WR;
        end
        S_WR: if (eng_done) begin
          if (eng_tmo) begin
            err <= E_TMO;
            st  <= S_STOP;
          end else if (!byte_ok) begin
            err <= E_DATA;
            st  <= S_STOP;
          end else begin
            m_left <= m_left - 1'b1;
            st     <= S_DATA;
          end
        end
        S_STOP: if (eng_done) st <= (err != E_NONE && !m_last) ? S_DRAIN : S_REPORT;
        S_DRAIN: if (desc_valid && desc_last) st <= S_REPORT;
        S_REPORT: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic desc_no_start_q;
  always_ff @(posedge clk) begin
    if (!rst_n) desc_no_start_q <= 1'b0;
    else if (desc_valid && ((st == S_IDLE) || (st == S_FETCH))) desc_no_start_q <= desc_no_start;
  end
endmodule

module i2c_xact_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       eng_cmd_valid,
  input logic [2:0] eng_cmd_op,
  input logic [7:0] eng_cmd_data,
  input logic       eng_done,
  input logic       desc_ready,
  input logic       wr_ready,
  input logic       rd_valid
);
  a_r9_hold_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cmd_valid && !eng_done |=> eng_cmd_valid && $stable(eng_cmd_op) && $stable(eng_cmd_data));

  a_r9_stop_final: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cmd_valid && eng_done && eng_cmd_op == 3'd2 |=> !eng_cmd_valid || eng_cmd_op == 3'd3);

  a_r4_delay_then_start: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cmd_valid && eng_done && eng_cmd_op == 3'd3 |=> eng_cmd_valid && eng_cmd_op == 3'd0);

  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    desc_ready |-> !eng_cmd_valid && !wr_ready);

  a_r7_rd_source: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(eng_done && eng_cmd_valid && eng_cmd_op >= 3'd5));
endmodule

bind i2c_xact_seq i2c_xact_seq_chk u_chk (.*);

// File: tb/tb_i2c_xact_seq.sv
module tb_i2c_xact_seq;
  typedef struct packed {
    logic [9:0] addr;
    logic rd, ten, ign, noack, nostart, last;
    logic [7:0] len;
  } desc_t;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [3:0] cfg_retries = '0;
  logic desc_ready, wr_ready, rd_valid, eng_cmd_valid, status_done, status_ok;
  logic [7:0] rd_data, eng_cmd_data;
  logic [2:0] eng_cmd_op;
  logic [1:0] status_err;
  logic [7:0] status_count;
  logic eng_done = 0, eng_ack = 0, eng_tmo = 0;
  logic [7:0] eng_rdata = 0;

  desc_t dq[16];
  int nd = 0, didx = 0, widx = 0;
  logic [7:0] wb[32];
  bit nack_at[256];
  bit tmo_at[256];
  desc_t cur;
  assign cur = (didx < 16) ? dq[didx] : '0;

  i2c_xact_seq dut (
    .clk(clk), .rst_n(rst_n), .cfg_retries(cfg_retries),
    .desc_valid(didx < nd), .desc_ready(desc_ready), .desc_addr(cur.addr),
    .desc_rd(cur.rd), .desc_ten(cur.ten), .desc_ign_nack(cur.ign),
    .desc_no_ack(cur.noack), .desc_no_start(cur.nostart), .desc_len(cur.len),
    .desc_last(cur.last), .wr_valid(1'b1), .wr_ready(wr_ready), .wr_data(wb[widx]),
    .rd_valid(rd_valid), .rd_data(rd_data), .eng_cmd_valid(eng_cmd_valid),
    .eng_cmd_op(eng_cmd_op), .eng_cmd_data(eng_cmd_data), .eng_done(eng_done),
    .eng_ack(eng_ack), .eng_tmo(eng_tmo), .eng_rdata(eng_rdata),
    .status_done(status_done), .status_ok(status_ok), .status_err(status_err),
    .status_count(status_count));

  int n_cmp = 0, n_bad = 0;
  string tag = "R11";
  int exp_op[$], exp_dat[$], exp_rd[$];
  int gk = 0, cidx = 0, ridx = 0;

  function automatic int rdbyte(int i);
    return (i * 7 + 3) & 255;
  endfunction

  always @(posedge clk) begin
    if (didx < nd && desc_ready) didx <= didx + 1;
    if (wr_ready) widx <= widx + 1;
  end

  int busy = 0, wait_n = 0, cur_i = 0;
  always @(negedge clk) begin
    if (eng_done) eng_done <= 0;
    else if (busy != 0) begin
      if (wait_n == 0) begin
        eng_done  <= 1;
        eng_ack   <= !nack_at[cur_i];
        eng_tmo   <= tmo_at[cur_i];
        eng_rdata <= 8'(rdbyte(cur_i));
        busy = 0;
      end else wait_n = wait_n - 1;
    end else if (eng_cmd_valid && rst_n) begin
      n_cmp++;
      if (cidx >= exp_op.size()) begin
        n_bad++;
        $display("FAIL %s: extra command op=%0d data=%02h, expected none", tag, eng_cmd_op, eng_cmd_data);
      end else if (eng_cmd_op != 3'(exp_op[cidx]) || eng_cmd_data != 8'(exp_dat[cidx])) begin
        n_bad++;
        $display("FAIL %s: command %0d got op=%0d data=%02h, expected op=%0d data=%02h",
                 tag, cidx, eng_cmd_op, eng_cmd_data, exp_op[cidx], exp_dat[cidx]);
      end
      cur_i = cidx;
      cidx++;
      busy = 1;
      wait_n = 1;
    end
    if (rd_valid) begin
      n_cmp++;
      if (ridx >= exp_rd.size() || rd_data != 8'(exp_rd[ridx])) begin
        n_bad++;
        $display("FAIL %s R7: read byte %0d got %02h, expected %02h", tag, ridx, rd_data,
                 (ridx < exp_rd.size()) ? exp_rd[ridx] : -1);
      end
      ridx++;
    end
  end

  function automatic int emitc(int op, int dat);
    exp_op.push_back(op);
    exp_dat.push_back(dat);
    gk++;
    return gk - 1;
  endfunction

  function automatic int addr_ph(int b, bit ign, int retries);
    int t = 0;
    while (1) begin
      int i = emitc(4, b);
      if (tmo_at[i]) return 3;
      if (!nack_at[i] || ign) return 0;
      if (t < (ign ? 0 : retries)) begin
        void'(emitc(2, 0)); void'(emitc(3, 0)); void'(emitc(0, 0));
        t++;
      end else return 1;
    end
    return 0;
  endfunction

  task automatic model(input int retries, output int e_err, output int e_cnt);
    int w = 0;
    e_err = 0; e_cnt = 0;
    void'(emitc(0, 0));
    for (int m = 0; m < nd && e_err == 0; m++) begin
      desc_t d = dq[m];
      if (!d.nostart) begin
        int a1 = d.ten ? (8'hF0 | ((int'(d.addr) >> 7) & 6)) : (((int'(d.addr) << 1) & 255) | int'(d.rd));
        if (m > 0) void'(emitc(1, 0));
        e_err = addr_ph(a1, d.ign, retries);
        if (e_err == 0 && d.ten) begin
          int i = emitc(4, int'(d.addr) & 255);
          if (tmo_at[i]) e_err = 3;
          else if (nack_at[i] && !d.ign) e_err = 1;
          if (e_err == 0 && d.rd) begin
            void'(emitc(1, 0));
            e_err = addr_ph(a1 | 1, d.ign, retries);
          end
        end
      end
      for (int b = 0; b < int'(d.len) && e_err == 0; b++) begin
        if (d.rd) begin
          int i = emitc(d.noack ? 7 : (b == int'(d.len) - 1 ? 6 : 5), 0);
          if (tmo_at[i]) e_err = 3;
          else exp_rd.push_back(rdbyte(i));
        end else begin
          int i = emitc(4, int'(wb[w]));
          w++;
          if (tmo_at[i]) e_err = 3;
          else if (nack_at[i] && !d.ign) e_err = 2;
        end
      end
      if (e_err == 0) e_cnt++;
    end
    void'(emitc(2, 0));
  endtask

  function automatic desc_t mk(int addr, bit rd, bit ten, bit ign, bit noack, bit ns, bit last, int len);
    desc_t d;
    d.addr = 10'(addr); d.rd = rd; d.ten = ten; d.ign = ign;
    d.noack = noack; d.nostart = ns; d.last = last; d.len = 8'(len);
    return d;
  endfunction

  task automatic clear();
    for (int i = 0; i < 256; i++) begin nack_at[i] = 0; tmo_at[i] = 0; end
    for (int i = 0; i < 32; i++) wb[i] = 8'(8'h31 + i * 11);
    for (int i = 0; i < 16; i++) dq[i] = '0;
    nd = 0;
  endtask

  task automatic run(input string t, input int retries, input int ndesc);
    int e_err, e_cnt, guard;
    tag = t;
    exp_op.delete(); exp_dat.delete(); exp_rd.delete();
    gk = 0; cidx = 0; ridx = 0;
    cfg_retries = 4'(retries);
    @(negedge clk);
    didx = 0; widx = 0;
    nd = ndesc;
    model(retries, e_err, e_cnt);
    guard = 0;
    while (!status_done && guard < 5000) begin @(negedge clk); guard++; end
    n_cmp++;
    if (guard >= 5000) begin
      n_bad++;
      $display("FAIL %s: watchdog, status_done never seen, expected a pulse", t);
    end else if (status_err != 2'(e_err) || status_ok != (e_err == 0) || status_count != 8'(e_cnt)) begin
      n_bad++;
      $display("FAIL %s R8: status err=%0d ok=%0d cnt=%0d, expected err=%0d ok=%0d cnt=%0d",
               t, status_err, status_ok, status_count, e_err, e_err == 0, e_cnt);
    end
    @(negedge clk);
    n_cmp++;
    if (cidx != exp_op.size() || ridx != exp_rd.size() || didx != nd) begin
      n_bad++;
      $display("FAIL %s R9 R10: cmds=%0d reads=%0d descs=%0d, expected %0d %0d %0d",
               t, cidx, ridx, didx, exp_op.size(), exp_rd.size(), nd);
    end
    nd = 0;
  endtask

  initial begin
    clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    n_cmp++;
    if (eng_cmd_valid || status_done) begin
      n_bad++;
      $display("FAIL R11: after reset valid=%0d done=%0d, expected 0 0", eng_cmd_valid, status_done);
    end

    // R1 R7: 7-bit write of two bytes then a three-byte read
    clear();
    dq[0] = mk(7'h52, 0, 0, 0, 0, 0, 0, 2);
    dq[1] = mk(7'h52, 1, 0, 0, 0, 0, 1, 3);
    run("R1 R7 R11", 2, 2);

    // R2 R3: 10-bit read then 10-bit write
    clear();
    dq[0] = mk(10'h2A5, 1, 1, 0, 0, 0, 0, 2);
    dq[1] = mk(10'h1C3, 0, 1, 0, 0, 0, 1, 1);
    run("R2 R3", 1, 2);

    // R4: NACKs then success on the final permitted retry
    clear();
    nack_at[1] = 1; nack_at[5] = 1;
    dq[0] = mk(7'h10, 0, 0, 0, 0, 0, 1, 1);
    run("R4", 2, 1);

    // R4 R10: retries run out, second descriptor dropped
    clear();
    nack_at[1] = 1; nack_at[5] = 1;
    dq[0] = mk(7'h11, 0, 0, 0, 0, 0, 0, 1);
    dq[1] = mk(7'h12, 1, 0, 0, 0, 0, 1, 2);
    run("R4 R8 R10", 1, 2);

    // R3 R4: 10-bit read, repeated address byte NACKed once
    clear();
    nack_at[4] = 1;
    dq[0] = mk(10'h0F7, 1, 1, 0, 0, 0, 1, 1);
    run("R3 R4", 1, 1);

    // R5: ignore-NACK, address and data NACKs, no retries taken
    clear();
    nack_at[1] = 1; nack_at[2] = 1; nack_at[3] = 1;
    dq[0] = mk(7'h33, 0, 0, 1, 0, 0, 1, 2);
    run("R5", 3, 1);

    // R6 R7: no-START write, no-ACK read, zero-length message
    clear();
    dq[0] = mk(7'h21, 0, 0, 0, 0, 0, 0, 1);
    dq[1] = mk(7'h21, 0, 0, 0, 0, 1, 0, 2);
    dq[2] = mk(7'h44, 1, 0, 0, 1, 0, 0, 2);
    dq[3] = mk(7'h45, 0, 0, 0, 0, 0, 1, 0);
    run("R6 R7", 0, 4);

    // R8 R10: data NACK in the second message, third dropped
    clear();
    nack_at[5] = 1;
    dq[0] = mk(7'h05, 0, 0, 0, 0, 0, 0, 1);
    dq[1] = mk(7'h06, 0, 0, 0, 0, 0, 0, 2);
    dq[2] = mk(7'h07, 0, 0, 0, 0, 0, 1, 1);
    run("R8 R10", 0, 3);

    // R8: timeout on the second read byte
    clear();
    tmo_at[3] = 1;
    dq[0] = mk(7'h68, 1, 0, 0, 0, 0, 1, 3);
    run("R8", 0, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule